// File: doc/BRIEF.md
# x86-64 Instruction Length Decoder

This block works out where one 64-bit-mode instruction ends. A byte window and a start offset are presented with a valid strobe. The block skips the leading legacy prefixes and at most one honoured REX byte. It then classifies the primary opcode and, for opcodes that carry one, looks at the ModRM byte and the SIB base. One clock edge later it reports the total byte length and where the opcode, the ModRM byte and the immediate (or absolute address) sit, all counted from the instruction's first byte.

The decoder covers a one-byte opcode subset:
- the eight two-operand ALU families;
- register and memory MOV;
- TEST;
- the 80/81/83 immediate group and the F6/F7 unary group;
- the C6/C7 store-immediate forms;
- the B0–BF register-immediate moves;
- the A0–A3 accumulator moves with an absolute address.

Any other opcode, an instruction longer than the architectural 15-byte limit, or a run of prefixes with no opcode inside that limit raises an invalid flag. A fetch front end would call it to find instruction boundaries before full decode. It is meant to see the same lengths as hardware, in particular for the prefix cases that change a length.

Top module: `x86_len_decoder`

## Requirements
- R1: Results appear on the clock edge after a cycle with `in_valid` high, with `out_valid` high for that one cycle. `out_valid` is low after any cycle with `in_valid` low, and the result fields hold their last value while no request arrives. Synchronous active-low reset clears every output to zero.
- R2: The bytes 26, 2E, 36, 3E, 64, 65, 66, 67, F2 and F3 are prefixes and are skipped, as is any byte 40–4F. `out_opc_ofs` equals the number of bytes skipped.
- R3: A byte 40–4F is a REX prefix, and its bit 3 is the W flag. REX only takes effect when it is the byte directly before the opcode. A REX that is followed by another prefix changes nothing.
- R4: ModRM length rules, under either address size and whatever the REX.B bit:
  - mod=11 adds nothing after the ModRM byte;
  - rm=100 with mod≠11 adds a SIB byte;
  - mod=01 adds a 1-byte displacement and mod=10 adds a 4-byte displacement;
  - mod=00 with rm=101 adds a 4-byte displacement.
- R5: When a SIB byte is present with mod=00 and SIB base=101 (bits 2:0), a 4-byte displacement follows. With mod=01 or 10 the displacement follows the mod field alone.
- R6: Immediate sizes:
  - These forms carry a 1-byte immediate: 04/0C/…/3C, 80, 83, A8, B0–B7 and C6.
  - These forms carry a word/dword immediate: 05/0D/…/3D, 81, A9 and C7. It is 2 bytes when 66 is present and REX.W is not, and 4 bytes otherwise.
- R7: Opcodes B8–BF carry an 8-byte immediate with REX.W, 2 bytes with 66 and no REX.W, and 4 bytes otherwise.
- R8: Opcodes A0–A3 have no ModRM and carry an 8-byte absolute address, or 4 bytes when 67 is present. REX.W does not change this.
- R9: For F6 and F7 the ModRM reg field (bits 5:3) decides the immediate. Values 0 and 1 carry a 1-byte immediate for F6 and a word/dword immediate (sized as in R6) for F7. Values 2–7 carry no immediate.
- R10: `out_invalid` is high if the computed length exceeds 15, if the opcode is outside the supported subset, or if the first 15 bytes are all prefixes.
- R11: `in_start` selects the window byte where the instruction begins. Bytes past the end of the window read as 00.
- R12: For a valid instruction:
  - `out_modrm_ofs` is `out_opc_ofs`+1 when `out_has_modrm` is high;
  - `out_imm_ofs` is the first byte after the opcode, ModRM, SIB and displacement, and equals `out_len` when there is no immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_window | input | WIN_BYTES*8 | Byte window; byte k is bits 8k+7:8k |
| in_start | input | OFS_W | Offset of the instruction's first byte in the window |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_invalid | output | 1 | Unsupported opcode, over-length or no opcode found |
| out_len | output | LEN_W | Total instruction length in bytes |
| out_opc_ofs | output | LEN_W | Offset of the opcode byte |
| out_has_modrm | output | 1 | Opcode carries a ModRM byte |
| out_modrm_ofs | output | LEN_W | Offset of the ModRM byte |
| out_imm_ofs | output | LEN_W | Offset of the immediate or absolute address |

## Verification
The sweeps go after the escape encodings and the cases where a prefix changes a length:
- **ModRM escapes.** rm=100 and rm=101 are crossed with every mod value, with REX.B set and with 67 present. A decoder that let REX.B cancel the SIB or RIP-relative escape would report r12/r13 forms one to four bytes short.
- **SIB base 101.** SIB base 101 is tried under each mod. A decoder that dropped the base-101 rule, or applied it to mod 01/10, would be off by four bytes.
- **REX placement and 66.** A REX that is then followed by 66, and 66 together with REX.W, separate the correct REX handling from one that honours any REX byte. They also separate it from one that lets 66 override W.
- **Operand-dependent sizes.** The F7 reg field and the moffs address size under 67 are checked, as are the 15-byte boundary and offsets that run off the window's end. A design wrong on any of these reports a length or an invalid flag that differs from the count computed in the bench.

// File: rtl/ild_pkg.sv
// Shared definitions for the instruction length decoder.
// Assumes 64-bit mode and the one-byte opcode map only.
package ild_pkg;

    // Immediate classes an opcode can carry
    typedef enum logic [2:0] {
        IMM_NONE,     // no immediate
        IMM_BYTE,     // always one byte
        IMM_WORDZ,    // 2 or 4 bytes, sized by 66 unless REX.W
        IMM_MOVWIDE,  // 2, 4 or 8 bytes (register-immediate move)
        IMM_MOFFS     // absolute address, 4 or 8 bytes by 67
    } imm_kind_t;

    // True for the legacy prefixes this block skips
    function automatic logic is_legacy_prefix(input logic [7:0] b);
        case (b)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
            8'h66, 8'h67, 8'hF2, 8'hF3: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    // True for a REX byte
    function automatic logic is_rex(input logic [7:0] b);
        return b[7:4] == 4'h4;
    endfunction

    // Byte count of an immediate class under the active prefixes
    function automatic logic [3:0] imm_bytes(input imm_kind_t kind,
                                             input logic opsz16,
                                             input logic addr32,
                                             input logic rex_w);
        case (kind)
            IMM_BYTE:    return 4'd1;
            IMM_WORDZ:   return (opsz16 && !rex_w) ? 4'd2 : 4'd4;
            IMM_MOVWIDE: return rex_w ? 4'd8 : (opsz16 ? 4'd2 : 4'd4);
            IMM_MOFFS:   return addr32 ? 4'd4 : 4'd8;
            default:     return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/ild_align.sv
// Picks LOOK consecutive bytes out of the window, starting at start_i.
// Assumes bytes that fall past the window end read as zero.
module ild_align #(
    parameter int WIN_BYTES = 32,
    parameter int OFS_W     = 5,
    parameter int LOOK      = 17
) (
    input  logic [WIN_BYTES*8-1:0] win_i,
    input  logic [OFS_W-1:0]       start_i,
    output logic [7:0]             bytes_o [LOOK]
);

    // Byte k of the output is window byte start+k, or zero beyond the end
    always_comb begin
        for (int k = 0; k < LOOK; k++) begin
            bytes_o[k] = '0;
            for (int w = 0; w < WIN_BYTES; w++) begin
                if (int'(start_i) + k == w) begin
                    bytes_o[k] = win_i[w*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/ild_prefix_scan.sv
// Walks the prefix run and reports where the opcode sits.
// Assumes at most SCAN_LEN bytes may precede the opcode; REX counts only
// when it is the last byte before the opcode.
module ild_prefix_scan
    import ild_pkg::*;
#(
    parameter int LOOK     = 17,
    parameter int SCAN_LEN = 15,
    parameter int IDX_W    = 4
) (
    input  logic [7:0]       bytes_i [LOOK],
    output logic             found_o,
    output logic [IDX_W-1:0] opc_idx_o,
    output logic             opsz16_o,
    output logic             addr32_o,
    output logic             rex_w_o
);

    logic rex_last;
    logic rex_w_seen;

    // First non-prefix byte is the opcode; collect prefix effects before it
    always_comb begin
        found_o    = 1'b0;
        opc_idx_o  = '0;
        opsz16_o   = 1'b0;
        addr32_o   = 1'b0;
        rex_last   = 1'b0;
        rex_w_seen = 1'b0;
        for (int k = 0; k < SCAN_LEN; k++) begin
            if (!found_o) begin
                if (is_legacy_prefix(bytes_i[k])) begin
                    if (bytes_i[k] == 8'h66) opsz16_o = 1'b1;
                    if (bytes_i[k] == 8'h67) addr32_o = 1'b1;
                    rex_last = 1'b0;
                end else if (is_rex(bytes_i[k])) begin
                    rex_last   = 1'b1;
                    rex_w_seen = bytes_i[k][3];
                end else begin
                    found_o   = 1'b1;
                    opc_idx_o = IDX_W'(k);
                end
            end
        end
        rex_w_o = rex_last & rex_w_seen;
    end

endmodule

// File: rtl/ild_opclass.sv
// Classifies a one-byte-map opcode: supported, has ModRM, immediate class.
// Assumes 64-bit mode; F6/F7 need the ModRM reg field to size the immediate.
module ild_opclass
    import ild_pkg::*;
(
    input  logic [7:0] opc_i,
    input  logic [2:0] modrm_reg_i,
    output logic       supported_o,
    output logic       has_modrm_o,
    imm_kind_t         imm_kind_o
);

    // Decode the opcode into its length class
    always_comb begin
        supported_o = 1'b1;
        has_modrm_o = 1'b0;
        imm_kind_o  = IMM_NONE;
        if (opc_i[7:6] == 2'b00 && opc_i[2:0] <= 3'd5) begin
            if (!opc_i[2])      has_modrm_o = 1'b1;
            else if (!opc_i[0]) imm_kind_o  = IMM_BYTE;
            else                imm_kind_o  = IMM_WORDZ;
        end else begin
            case (opc_i)
                8'h84, 8'h85, 8'h88, 8'h89, 8'h8A, 8'h8B: has_modrm_o = 1'b1;
                8'h80, 8'h83, 8'hC6: begin
                    has_modrm_o = 1'b1;
                    imm_kind_o  = IMM_BYTE;
                end
                8'h81, 8'hC7: begin
                    has_modrm_o = 1'b1;
                    imm_kind_o  = IMM_WORDZ;
                end
                8'hF6: begin
                    has_modrm_o = 1'b1;
                    imm_kind_o  = (modrm_reg_i < 3'd2) ? IMM_BYTE : IMM_NONE;
                end
                8'hF7: begin
                    has_modrm_o = 1'b1;
                    imm_kind_o  = (modrm_reg_i < 3'd2) ? IMM_WORDZ : IMM_NONE;
                end
                8'hA8:                      imm_kind_o = IMM_BYTE;
                8'hA9:                      imm_kind_o = IMM_WORDZ;
                8'hA0, 8'hA1, 8'hA2, 8'hA3: imm_kind_o = IMM_MOFFS;
                default: begin
                    if (opc_i[7:3] == 5'b10110)      imm_kind_o  = IMM_BYTE;
                    else if (opc_i[7:3] == 5'b10111) imm_kind_o  = IMM_MOVWIDE;
                    else                             supported_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ild_modrm.sv
// Counts the bytes after a ModRM byte: SIB plus displacement.
// Assumes 64-bit mode rules, which are the same for both address sizes
// and ignore REX.B.
module ild_modrm (
    input  logic [7:0] modrm_i,
    input  logic [7:0] sib_i,
    output logic [2:0] extra_o
);

    logic [1:0] mode;
    logic [2:0] rm;

    assign mode = modrm_i[7:6];
    assign rm   = modrm_i[2:0];

    // SIB and displacement bytes implied by mod, rm and the SIB base
    always_comb begin
        extra_o = 3'd0;
        if (mode != 2'b11) begin
            if (rm == 3'b100) begin
                extra_o = 3'd1;
                if (mode == 2'b00 && sib_i[2:0] == 3'b101) extra_o = 3'd5;
            end
            if (mode == 2'b00 && rm == 3'b101) extra_o = 3'd4;
            if (mode == 2'b01) extra_o = extra_o + 3'd1;
            if (mode == 2'b10) extra_o = extra_o + 3'd4;
        end
    end

endmodule

// File: rtl/x86_len_decoder.sv
// Top of the instruction length decoder: aligns the window, scans prefixes,
// classifies the opcode and registers length and field offsets.
// Assumes one request per cycle with a fixed one-cycle latency.
module x86_len_decoder
    import ild_pkg::*;
#(
    parameter int WIN_BYTES = 32,
    parameter int MAX_LEN   = 15,
    parameter int OFS_W     = $clog2(WIN_BYTES),
    parameter int LEN_W     = $clog2(MAX_LEN + 16)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [WIN_BYTES*8-1:0] in_window,
    input  logic [OFS_W-1:0]       in_start,
    output logic                   out_valid,
    output logic                   out_invalid,
    output logic [LEN_W-1:0]       out_len,
    output logic [LEN_W-1:0]       out_opc_ofs,
    output logic                   out_has_modrm,
    output logic [LEN_W-1:0]       out_modrm_ofs,
    output logic [LEN_W-1:0]       out_imm_ofs
);

    localparam int LOOK  = MAX_LEN + 2;
    localparam int IDX_W = $clog2(MAX_LEN);

    logic [7:0]       ibytes [LOOK];
    logic             found;
    logic [IDX_W-1:0] opc_idx;
    logic             opsz16;
    logic             addr32;
    logic             rex_w;
    logic [IDX_W:0]   idx_modrm;
    logic [IDX_W:0]   idx_sib;
    logic [7:0]       opc_byte;
    logic [7:0]       modrm_byte;
    logic [7:0]       sib_byte;
    logic             supported;
    logic             has_modrm;
    imm_kind_t        imm_kind;
    logic [2:0]       modrm_extra;
    logic [LEN_W-1:0] imm_ofs_c;
    logic [LEN_W-1:0] len_c;
    logic             invalid_c;

    ild_align #(
        .WIN_BYTES (WIN_BYTES),
        .OFS_W     (OFS_W),
        .LOOK      (LOOK)
    ) u_align (
        .win_i   (in_window),
        .start_i (in_start),
        .bytes_o (ibytes)
    );

    ild_prefix_scan #(
        .LOOK     (LOOK),
        .SCAN_LEN (MAX_LEN),
        .IDX_W    (IDX_W)
    ) u_scan (
        .bytes_i   (ibytes),
        .found_o   (found),
        .opc_idx_o (opc_idx),
        .opsz16_o  (opsz16),
        .addr32_o  (addr32),
        .rex_w_o   (rex_w)
    );

    // Pick the opcode byte and the two bytes that may be ModRM and SIB
    always_comb begin
        idx_modrm  = {1'b0, opc_idx} + 1'b1;
        idx_sib    = {1'b0, opc_idx} + 2'd2;
        opc_byte   = ibytes[opc_idx];
        modrm_byte = ibytes[idx_modrm];
        sib_byte   = ibytes[idx_sib];
    end

    ild_opclass u_class (
        .opc_i       (opc_byte),
        .modrm_reg_i (modrm_byte[5:3]),
        .supported_o (supported),
        .has_modrm_o (has_modrm),
        .imm_kind_o  (imm_kind)
    );

    ild_modrm u_modrm (
        .modrm_i (modrm_byte),
        .sib_i   (sib_byte),
        .extra_o (modrm_extra)
    );

    // Sum the pieces into the immediate offset, total length and validity
    always_comb begin
        imm_ofs_c = LEN_W'(opc_idx) + LEN_W'(1);
        if (has_modrm) imm_ofs_c = imm_ofs_c + LEN_W'(1) + LEN_W'(modrm_extra);
        len_c     = imm_ofs_c + LEN_W'(imm_bytes(imm_kind, opsz16, addr32, rex_w));
        invalid_c = !found || !supported || (len_c > LEN_W'(MAX_LEN));
    end

    // Register the result; fields only update when a request arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_invalid   <= 1'b0;
            out_len       <= '0;
            out_opc_ofs   <= '0;
            out_has_modrm <= 1'b0;
            out_modrm_ofs <= '0;
            out_imm_ofs   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_invalid   <= invalid_c;
                out_len       <= len_c;
                out_opc_ofs   <= LEN_W'(opc_idx);
                out_has_modrm <= has_modrm;
                out_modrm_ofs <= LEN_W'(idx_modrm);
                out_imm_ofs   <= imm_ofs_c;
            end
        end
    end

endmodule

// File: rtl/x86_len_decoder_chk.sv
// Protocol and consistency properties of the length decoder outputs.
// Assumes it is bound into x86_len_decoder.
module x86_len_decoder_chk #(
    parameter int LEN_W   = 5,
    parameter int MAX_LEN = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_invalid,
    input logic [LEN_W-1:0] out_len,
    input logic [LEN_W-1:0] out_opc_ofs,
    input logic             out_has_modrm,
    input logic [LEN_W-1:0] out_modrm_ofs,
    input logic [LEN_W-1:0] out_imm_ofs
);

    logic good;
    assign good = out_valid && !out_invalid;

    p_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_len) && $stable(out_imm_ofs)));

    p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> (out_len != '0 && out_len <= LEN_W'(MAX_LEN)));

    p_modrm_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (good && out_has_modrm) |->
            ({1'b0, out_modrm_ofs} == {1'b0, out_opc_ofs} + 1'b1));

    p_field_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> (out_opc_ofs < out_len && out_imm_ofs <= out_len
                  && out_imm_ofs > out_opc_ofs));

endmodule

bind x86_len_decoder x86_len_decoder_chk #(
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .out_invalid   (out_invalid),
    .out_len       (out_len),
    .out_opc_ofs   (out_opc_ofs),
    .out_has_modrm (out_has_modrm),
    .out_modrm_ofs (out_modrm_ofs),
    .out_imm_ofs   (out_imm_ofs)
);

// File: tb/x86_len_decoder_tb.sv
// Self-checking bench: directed cases plus sweeps over opcodes, prefixes,
// ModRM/SIB values and start offsets against a length count done here.
module x86_len_decoder_tb;

    localparam int WB    = 32;
    localparam int OFS_W = 5;
    localparam int LEN_W = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [WB*8-1:0]   in_window;
    logic [OFS_W-1:0]  in_start;
    logic              out_valid;
    logic              out_invalid;
    logic [LEN_W-1:0]  out_len;
    logic [LEN_W-1:0]  out_opc_ofs;
    logic              out_has_modrm;
    logic [LEN_W-1:0]  out_modrm_ofs;
    logic [LEN_W-1:0]  out_imm_ofs;

    int checks = 0;
    int errors = 0;
    logic [7:0] qb [32];
    int qn = 0;

    always #2 clk = ~clk;

    x86_len_decoder u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_window     (in_window),
        .in_start      (in_start),
        .out_valid     (out_valid),
        .out_invalid   (out_invalid),
        .out_len       (out_len),
        .out_opc_ofs   (out_opc_ofs),
        .out_has_modrm (out_has_modrm),
        .out_modrm_ofs (out_modrm_ofs),
        .out_imm_ofs   (out_imm_ofs)
    );

    task automatic chk(input string tag, input string field, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, field, act, exp);
        end
    endtask

    task automatic qclr();
        qn = 0;
    endtask

    task automatic qpush(input logic [7:0] b);
        qb[qn] = b;
        qn++;
    endtask

    // Bytes written in reading order, first byte in the highest position
    task automatic put_hex(input logic [127:0] s, input int n);
        for (int j = 0; j < n; j++) qpush(s[(n-1-j)*8 +: 8]);
    endtask

    task automatic fill(input int n);
        for (int j = 0; j < n; j++) qpush(8'h11);
    endtask

    function automatic logic [7:0] rb(input logic [WB*8-1:0] w, input int st, input int k);
        int p;
        p = st + k;
        return (p < WB) ? w[p*8 +: 8] : 8'h00;
    endfunction

    // Length count from the requirements
    task automatic ref_decode(input logic [WB*8-1:0] w, input int st,
                              output int e_len, output int e_opc, output int e_hm,
                              output int e_imm, output int e_inv);
        int k; bit found; bit osz; bit asz; bit rw; bit rl; bit wz; bit sup;
        int ex; int imm; int iz;
        logic [7:0] c; logic [7:0] op; logic [7:0] m; logic [7:0] s;
        k = 0; found = 0; osz = 0; asz = 0; rw = 0; rl = 0;
        while (!found && k < 15) begin
            c = rb(w, st, k);
            case (c)
                8'h66: begin osz = 1; rl = 0; end
                8'h67: begin asz = 1; rl = 0; end
                8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'hF2, 8'hF3: rl = 0;
                default: if (c[7:4] == 4'h4) begin rl = 1; rw = c[3]; end
                         else found = 1;
            endcase
            if (!found) k++;
        end
        e_opc = k; e_hm = 0; e_imm = 0; e_len = 0; e_inv = 1;
        if (!found) return;
        op = rb(w, st, k); m = rb(w, st, k+1); s = rb(w, st, k+2);
        wz = rl && rw;
        iz = (osz && !wz) ? 2 : 4;
        sup = 1; imm = 0;
        if (op < 8'h40 && op[2:0] <= 3'd5) begin
            if (op[2:0] < 3'd4) e_hm = 1;
            else imm = (op[2:0] == 3'd4) ? 1 : iz;
        end else begin
            case (op)
                8'h84, 8'h85, 8'h88, 8'h89, 8'h8A, 8'h8B: e_hm = 1;
                8'h80, 8'h83, 8'hC6: begin e_hm = 1; imm = 1; end
                8'h81, 8'hC7: begin e_hm = 1; imm = iz; end
                8'hF6: begin e_hm = 1; imm = (m[5:3] < 2) ? 1 : 0; end
                8'hF7: begin e_hm = 1; imm = (m[5:3] < 2) ? iz : 0; end
                8'hA8: imm = 1;
                8'hA9: imm = iz;
                8'hA0, 8'hA1, 8'hA2, 8'hA3: imm = asz ? 4 : 8;
                default:
                    if (op >= 8'hB0 && op <= 8'hB7) imm = 1;
                    else if (op >= 8'hB8) imm = wz ? 8 : (osz ? 2 : 4);
                    else sup = 0;
            endcase
            if (op >= 8'hC0 && op != 8'hC6 && op != 8'hC7 && op != 8'hF6 && op != 8'hF7) sup = 0;
        end
        ex = 0;
        if (e_hm && m[7:6] != 2'b11) begin
            if (m[2:0] == 3'b100) begin
                ex = 1;
                if (m[7:6] == 2'b00 && s[2:0] == 3'b101) ex += 4;
            end
            if (m[7:6] == 2'b00 && m[2:0] == 3'b101) ex += 4;
            if (m[7:6] == 2'b01) ex += 1;
            if (m[7:6] == 2'b10) ex += 4;
        end
        e_imm = k + 1 + e_hm + ex;
        e_len = e_imm + imm;
        e_inv = (!sup || e_len > 15) ? 1 : 0;
    endtask

    function automatic string tag_for(input int op);
        if (op >= 8'hA0 && op <= 8'hA3) return "R8";
        if (op >= 8'hB8 && op <= 8'hBF) return "R7";
        if (op == 8'hF6 || op == 8'hF7) return "R9";
        if (op >= 8'h84 && op <= 8'h8B) return "R4";
        return "R6";
    endfunction

    // Drive the queued bytes at offset st; lit: -1 none, 0 expect invalid, else length
    task automatic run(input int st, input string tag, input int lit);
        logic [WB*8-1:0] w;
        int e_len, e_opc, e_hm, e_imm, e_inv;
        w = {WB{8'hCC}};
        for (int j = 0; j < qn; j++) if (st + j < WB) w[(st+j)*8 +: 8] = qb[j];
        @(negedge clk);
        in_valid  = 1'b1;
        in_window = w;
        in_start  = OFS_W'(st);
        @(negedge clk);
        in_valid = 1'b0;
        ref_decode(w, st, e_len, e_opc, e_hm, e_imm, e_inv);
        chk({"R1/", tag}, "valid", int'(out_valid), 1);
        chk({"R10/", tag}, "invalid", int'(out_invalid), e_inv);
        if (e_inv == 0) begin
            chk(tag, "len", int'(out_len), e_len);
            chk({"R2/", tag}, "opc_ofs", int'(out_opc_ofs), e_opc);
            chk(tag, "has_modrm", int'(out_has_modrm), e_hm);
            if (e_hm != 0) chk({"R12/", tag}, "modrm_ofs", int'(out_modrm_ofs), e_opc + 1);
            chk({"R12/", tag}, "imm_ofs", int'(out_imm_ofs), e_imm);
        end
        if (lit == 0) chk(tag, "invalid literal", int'(out_invalid), 1);
        else if (lit > 0) chk(tag, "len literal", int'(out_len), lit);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int held;
        rst_n = 1'b0; in_valid = 1'b0; in_window = '0; in_start = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "reset valid", int'(out_valid), 0);
        chk("R1", "reset len", int'(out_len), 0);
        chk("R1", "reset invalid", int'(out_invalid), 0);

        // Directed cases with lengths counted by hand
        qclr(); put_hex(128'h4889F9, 3);                         run(0, "R3", 3);
        qclr(); put_hex(128'h674889F9, 4);                       run(0, "R2", 4);
        qclr(); put_hex(128'h67A2, 2); fill(10);                 run(0, "R8", 6);
        qclr(); put_hex(128'hA2, 1); fill(10);                   run(0, "R8", 9);
        qclr(); put_hex(128'h48A1, 2); fill(10);                 run(0, "R8", 10);
        qclr(); put_hex(128'h486681C0, 4); fill(10);             run(0, "R3", 6);
        qclr(); put_hex(128'h664881C0, 4); fill(10);             run(0, "R6", 8);
        qclr(); put_hex(128'h6681C0, 3); fill(10);               run(0, "R6", 5);
        qclr(); put_hex(128'h83C001, 3);                         run(0, "R6", 3);
        qclr(); put_hex(128'h48B8, 2); fill(10);                 run(0, "R7", 10);
        qclr(); put_hex(128'h66B8, 2); fill(10);                 run(0, "R7", 4);
        qclr(); put_hex(128'hB8, 1); fill(10);                   run(0, "R7", 5);
        qclr(); put_hex(128'h6648B8, 3); fill(10);               run(0, "R7", 11);
        qclr(); put_hex(128'h418B0424, 4);                       run(0, "R4", 4);
        qclr(); put_hex(128'h418B4500, 4);                       run(0, "R4", 4);
        qclr(); put_hex(128'h418B05, 3); fill(10);               run(0, "R4", 7);
        qclr(); put_hex(128'h678B0425, 4); fill(10);             run(0, "R4", 8);
        qclr(); put_hex(128'h8B0425, 3); fill(10);               run(0, "R5", 7);
        qclr(); put_hex(128'h8B442508, 4);                       run(0, "R5", 4);
        qclr(); put_hex(128'hF7D8, 2);                           run(0, "R9", 2);
        qclr(); put_hex(128'hF7C0, 2); fill(10);                 run(0, "R9", 6);
        qclr(); put_hex(128'h66F7C0, 3); fill(10);               run(0, "R9", 5);
        qclr(); put_hex(128'hF6C001, 3);                         run(0, "R9", 3);
        qclr(); put_hex(128'h0F05, 2);                           run(0, "R10", 0);
        qclr(); put_hex(128'h90, 1);                             run(0, "R10", 0);
        qclr(); for (int j = 0; j < 13; j++) qpush(8'h66); put_hex(128'h01C8, 2); run(0, "R10", 15);
        qclr(); for (int j = 0; j < 14; j++) qpush(8'h66); put_hex(128'h01C8, 2); run(0, "R10", 0);
        qclr(); for (int j = 0; j < 15; j++) qpush(8'h66);      run(0, "R10", 0);
        qclr(); put_hex(128'h8B04, 2);                           run(30, "R11", 3);
        qclr(); put_hex(128'h89C8, 2);                           run(20, "R11", 2);

        // R1: idle cycle drops valid and holds fields
        held = int'(out_len);
        @(negedge clk); in_window = '0; in_start = '0;
        @(negedge clk);
        chk("R1", "idle valid", int'(out_valid), 0);
        chk("R1", "idle hold len", int'(out_len), held);

        // Opcode x prefix x ModRM sweep
        for (int op = 0; op < 256; op++) begin
            for (int p = 0; p < 7; p++) begin
                for (int v = 0; v < 6; v++) begin
                    qclr();
                    case (p)
                        1: qpush(8'h66);
                        2: qpush(8'h67);
                        3: qpush(8'h48);
                        4: begin qpush(8'h66); qpush(8'h48); end
                        5: begin qpush(8'h48); qpush(8'h66); end
                        6: begin qpush(8'hF3); qpush(8'h41); end
                        default: ;
                    endcase
                    qpush(op[7:0]);
                    case (v)
                        0: qpush(8'hC1);
                        1: begin qpush(8'h04); qpush(8'h25); end
                        2: begin qpush(8'h44); qpush(8'h10); end
                        3: qpush(8'h85);
                        4: qpush(8'h05);
                        default: begin qpush(8'h1C); qpush(8'h65); end
                    endcase
                    fill(10);
                    run(0, tag_for(op), -1);
                end
            end
        end

        // Full ModRM sweep with SIB variants and address/REX prefixes
        for (int m = 0; m < 256; m++) begin
            for (int sv = 0; sv < 4; sv++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] sb;
                    case (sv)
                        0: sb = 8'h25;
                        1: sb = 8'h20;
                        2: sb = 8'h05;
                        default: sb = 8'h44;
                    endcase
                    qclr();
                    if (p == 1) qpush(8'h67);
                    if (p == 2) qpush(8'h41);
                    qpush(8'h8B); qpush(m[7:0]); qpush(sb);
                    fill(8);
                    run(0, (sb[2:0] == 3'b101) ? "R5" : "R4", -1);
                end
            end
        end

        // Start offset sweep across the whole window
        for (int st = 0; st < WB; st++) begin
            qclr(); put_hex(128'h6681C03412, 5);
            run(st, "R11", -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule